// File: doc/BRIEF.md
# Four-Channel Programmable Expiry Timer

This block holds four independent one-shot timers that all watch a single free-running 4-bit count. A channel is programmed by raising a load strobe for one clock together with a 2-bit channel number and a 4-bit duration. A non-zero duration arms the channel. A zero duration leaves it disabled.

An armed channel compares its stored duration with the shared count on every clock. At the first match after the load, its expiry flag goes high and stays high, and the channel disarms. Loading the channel again clears the flag and starts a new interval.

Since the count is shared, the delay from a load to its expiry depends on the count value at the moment of the load. It is always between 1 and 16 clocks.

Top module: `expiry_timer4`

## Requirements
- R1: While synchronous reset is high and on the first cycle after it, all four expiry flags are low, every channel is disarmed, and the shared count is 0.
- R2: The shared 4-bit count increments by one on every clock edge outside reset and wraps from 15 to 0.
- R3: A load strobe programs only the channel whose number (0 to 3) is on the select input. The flags of the other three channels do not change.
- R4: Suppose a load carries a duration d from 1 to 15 and is sampled when the count is c. The flag of that channel then rises exactly ((d - c - 1) mod 16) + 1 clock edges after the load edge. That is the first later edge at which the count equals d.
- R5: A load with duration 0 disables the channel, and its flag never rises for as long as the channel is not reloaded.
- R6: Once high, an expiry flag stays high until its own channel is loaded again.
- R7: Any load to a channel, of any duration, makes that channel's flag low after the load edge.
- R8: When a load to a channel coincides with that channel's expiry match, the load wins. The flag stays low, and the next expiry is timed from the new load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle program strobe |
| sel | input | 2 | Channel number to program |
| din | input | 4 | Duration; 0 disables the channel |
| expired | output | 4 | Sticky expiry flag, one bit per channel |

## Verification
A wrong shared count shows up as a shifted expiry time on every channel that is loaded afterwards. This is caught within at most 16 clocks of the load, because the sweep checks the flag on every cycle against the arithmetic latency. A stale arm bit or stored duration appears either as a flag that rises for a zero duration or as a flag that rises early, late or not at all. Corrupted flag storage appears as a flag that drops without a reload, or as a change on a channel that was not selected. Both are seen on the very next sampled cycle.

// File: rtl/expiry_timer4.sv
module expiry_timer4 #(
  parameter int NCH = 4,
  parameter int DW  = 4,
  localparam int SW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [SW-1:0]  sel,
  input  logic [DW-1:0]  din,
  output logic [NCH-1:0] expired
);

  logic [DW-1:0]          cnt;
  logic [NCH-1:0]         arm;
  logic [NCH-1:0][DW-1:0] dur_q;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ld, hit;
    assign ld  = load && (sel == SW'(i));
    assign hit = arm[i] && (cnt == dur_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        arm[i]     <= 1'b0;
        dur_q[i]   <= '0;
        expired[i] <= 1'b0;
      end else if (ld) begin
        dur_q[i]   <= din;
        arm[i]     <= (din != '0);
        expired[i] <= 1'b0;
      end else if (hit) begin
        arm[i]     <= 1'b0;
        expired[i] <= 1'b1;
      end
    end
  end

endmodule

module expiry_timer4_chk #(
  parameter int NCH = 4,
  parameter int DW  = 4,
  localparam int SW = $clog2(NCH)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   load,
  input logic [SW-1:0]          sel,
  input logic [DW-1:0]          din,
  input logic [NCH-1:0]         expired,
  input logic [DW-1:0]          cnt,
  input logic [NCH-1:0]         arm,
  input logic [NCH-1:0][DW-1:0] dur_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (expired == '0 && arm == '0 && cnt == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == DW'($past(cnt) + 1'b1));

  // R5
  zero_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (load && din == '0) |=> !arm[$past(sel)]);

  // R7
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired[$past(sel)]);

  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (expired[i] && !(load && sel == SW'(i))) |=> expired[i]);

    // R4
    rise_match_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(expired[i]) |-> ($past(arm[i]) && $past(cnt) == $past(dur_q[i])));

    // R3
    other_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (load && sel != SW'(i) && !arm[i]) |=> $stable(expired[i]));
  end

endmodule

bind expiry_timer4 expiry_timer4_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .sel(sel), .din(din),
  .expired(expired), .cnt(cnt), .arm(arm), .dur_q(dur_q)
);

// File: tb/expiry_timer4_bench.sv
`timescale 1ns/1ps
module expiry_timer4_bench;
  logic clk = 0, rst = 1, load = 0;
  logic [1:0] sel = 0;
  logic [3:0] din = 0;
  logic [3:0] expired;
  logic [3:0] bcnt;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  expiry_timer4 u_expiry_timer4 (
    .clk(clk), .rst(rst), .load(load), .sel(sel), .din(din), .expired(expired)
  );

  // count value the design holds after each edge (R2 model)
  always @(posedge clk) bcnt <= rst ? 4'd0 : bcnt + 4'd1;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lat(input logic [3:0] d, input logic [3:0] c);
    return int'(4'(d - c - 4'd1)) + 1;
  endfunction

  // load channel ch with d, return count sampled with the load
  task automatic do_load(input int ch, input logic [3:0] d, output logic [3:0] c);
    c = bcnt;
    load = 1; sel = 2'(ch); din = d;
    step();
    load = 0;
  endtask

  task automatic trial(input int ch, input logic [3:0] d);
    logic [3:0] c, others, msk;
    int j;
    msk = 4'(1 << ch);
    others = expired & ~msk;
    do_load(ch, d, c);
    j = lat(d, c);
    chk("R7", expired & msk, 4'h0);
    for (int n = 1; n <= 18; n++) begin
      step();
      if (d == 0) chk("R5", expired & msk, 4'h0);
      else if (n > 16) chk("R6", expired & msk, msk);
      else chk("R4", expired & msk, (n >= j) ? msk : 4'h0);
      chk("R3", expired & ~msk, others);
    end
  endtask

  initial begin
    logic [3:0] c, c2;
    int j, j2;
    step();
    chk("R1", expired, 4'h0);
    step();
    chk("R1", expired, 4'h0);
    rst = 0;
    step();
    chk("R1", expired, 4'h0);
    for (int ch = 0; ch < 4; ch++)
      for (int d = 0; d < 16; d++) begin
        for (int w = 0; w < (ch * 5 + d * 3) % 7; w++) step();
        trial(ch, 4'(d));
      end
    // R8: reload at the exact expiry edge
    for (int ch = 0; ch < 4; ch++) begin
      do_load(ch, 4'(ch + 3), c);
      j = lat(4'(ch + 3), c);
      for (int n = 1; n < j; n++) step();
      chk("R8", expired[ch], 1'b0);
      do_load(ch, 4'(ch + 9), c2);
      chk("R8", {3'b0, expired[ch]}, 4'h0);
      chk("R8", c2, 4'(ch + 3));
      j2 = lat(4'(ch + 9), c2);
      for (int n = 1; n <= j2; n++) begin
        step();
        chk("R8", {3'b0, expired[ch]}, (n >= j2) ? 4'h1 : 4'h0);
      end
    end
    // R5: zero after expiry clears and stays low
    do_load(2, 4'd0, c);
    for (int n = 0; n < 20; n++) begin
      step();
      chk("R5", {3'b0, expired[2]}, 4'h0);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule